// File: doc/BRIEF.md
# Low-Power Seconds Counter with Alarm

This block keeps wall-clock time as a 47-bit counter that advances once per slow-clock pulse. The low 15 bits count fractions of a second at 32768 pulses per second, and the upper 32 bits form a whole-seconds value. Software reaches the counter, a seconds alarm, a control word, a status flag and a scratch glitch-detect word through a 32-bit register port. Each register sits at its own word offset: control 0x04, status 0x18, counter high 0x1C, counter low 0x20, alarm 0x24 and glitch-detect 0x30.

The slow clock is modelled as a qualifying pulse, `slowTick`, on the single block clock. Every control change passes through a short pipeline that advances only on slow pulses before it acts on the counter and the alarm logic. The control word read back shows the state after that pipeline, so software writes a setting and then polls until the setting shows up. The counter can be loaded only while counting is stopped. When the seconds value equals the alarm value and the alarm is enabled, a sticky pending flag is set. That flag drives an interrupt line and a wakeup line, each gated by its own enable.

Top module: `rtc_lp_counter`

## Requirements
- R1: After reset every register reads zero and both `alarmIrq` and `wakeReq` are low.
- R2: While the applied count enable is 1, each clock with `slowTick` high adds exactly one to the 47-bit counter. With the enable at 0, or with no pulse, the counter holds. 32768 pulses carry exactly one into bit 15, the lowest seconds bit.
- R3: A write to control (offset 0x04) uses bit 0 as count enable, bit 1 as alarm enable and bit 3 as wakeup enable. The write takes effect, and shows in the readback at those same bits, on the third `slowTick` pulse after the write and not before.
- R4: Counter low (0x20) reads counter bits 31:0. Counter high (0x1C) reads counter bits 46:32 in its bits 14:0, and its bits 31:15 read zero.
- R5: Writes to counter low replace bits 31:0, and writes to counter high replace bits 46:32 from data bits 14:0. Both are accepted only while the applied count enable is 0 and are ignored otherwise.
- R6: The alarm register (0x24) reads back what was written. The pending flag, status (0x18) bit 0, is set one clock after the applied alarm enable is 1 and counter bits 46:15 equal the alarm value. No flag is set while the values differ.
- R7: Writing status with data bit 0 equal to 1 clears the pending flag, and writing 0 leaves it unchanged. If a set condition holds in the same clock, the set wins.
- R8: `alarmIrq` is high exactly when the pending flag and the applied alarm enable are both 1. `wakeReq` is high exactly when the pending flag and the applied wakeup enable are both 1.
- R9: The glitch-detect register (0x30) stores and returns a full 32-bit value, such as the initialisation word 0x41736166.
- R10: Offsets other than the six listed read zero, and writes to them change no register.
- R11: Counter low carries into counter high, and the full counter wraps from all ones to zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Block clock |
| rstN | input | 1 | Asynchronous active-low reset |
| slowTick | input | 1 | One-clock slow-domain pulse, 32768 per second |
| busWr | input | 1 | Register write strobe |
| busAddr | input | 6 | Register byte offset |
| busWdata | input | 32 | Write data |
| busRdata | output | 32 | Read data for `busAddr`, combinational |
| alarmIrq | output | 1 | Alarm interrupt |
| wakeReq | output | 1 | Wakeup request |

## Verification
Read data comes straight from `busAddr`, so every register effect is visible one clock after the write or pulse edge that caused it. The bench drives on falling edges and samples there. A control setting becomes visible only after the third pulse, so the bench checks the readback and the counter after two pulses and again after three. The pending flag rises one clock after the alarm match appears, so the bench waits one idle clock after the alarm write before it reads status and the two request lines. Runs of pulses are held for consecutive clocks, which makes the number of counter increments equal the number of clocks the pulse was held.

// File: rtl/rtc_lp_pkg.sv
package rtc_lp_pkg;
  localparam int CNT_W   = 47;
  localparam int FRAC_W  = 15;
  localparam int SEC_W   = CNT_W - FRAC_W;
  localparam int HI_W    = CNT_W - 32;
  localparam int ADDR_W  = 6;
  localparam int DATA_W  = 32;

  localparam logic [ADDR_W-1:0] OFF_CTRL   = 6'h04;
  localparam logic [ADDR_W-1:0] OFF_STATUS = 6'h18;
  localparam logic [ADDR_W-1:0] OFF_CNTHI  = 6'h1C;
  localparam logic [ADDR_W-1:0] OFF_CNTLO  = 6'h20;
  localparam logic [ADDR_W-1:0] OFF_ALARM  = 6'h24;
  localparam logic [ADDR_W-1:0] OFF_GLITCH = 6'h30;

  typedef struct packed {
    logic wakeEn;
    logic alarmEn;
    logic cntEn;
  } ctrlBits_t;

  typedef struct packed {
    logic wrLo;
    logic wrHi;
    logic wrAlarm;
    logic advance;
  } dpStrobe_t;
endpackage

// File: rtl/rtc_lp_datapath.sv
module rtc_lp_datapath
  import rtc_lp_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  dpStrobe_t         strobe,
  input  logic [DATA_W-1:0] wrData,
  output logic [CNT_W-1:0]  cntVal,
  output logic [SEC_W-1:0]  alarmVal,
  output logic              secsMatch
);
  logic [CNT_W-1:0] cntReg;
  logic [SEC_W-1:0] alarmReg;

  // Loads and advances never coincide: the control side allows loads only
  // while counting is stopped and advances only while it runs.
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      cntReg <= '0;
    end else if (strobe.advance) begin
      cntReg <= cntReg + CNT_W'(1);
    end else begin
      if (strobe.wrLo) cntReg[31:0]      <= wrData;
      if (strobe.wrHi) cntReg[CNT_W-1:32] <= wrData[HI_W-1:0];
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)               alarmReg <= '0;
    else if (strobe.wrAlarm) alarmReg <= wrData[SEC_W-1:0];
  end

  assign cntVal    = cntReg;
  assign alarmVal  = alarmReg;
  assign secsMatch = (cntReg[CNT_W-1:FRAC_W] == alarmReg);
endmodule

// File: rtl/rtc_lp_ctrl.sv
module rtc_lp_ctrl
  import rtc_lp_pkg::*;
#(
  parameter int SYNC_STAGES = 3
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              slowTick,
  input  logic              busWr,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic [DATA_W-1:0] busWdata,
  input  logic [CNT_W-1:0]  cntVal,
  input  logic [SEC_W-1:0]  alarmVal,
  input  logic              secsMatch,
  output dpStrobe_t         strobe,
  output ctrlBits_t         slowCtrl,
  output logic              pendingFlag,
  output logic [DATA_W-1:0] busRdata
);
  ctrlBits_t                    ctrlReg;
  ctrlBits_t [SYNC_STAGES-1:0]  syncPipe;
  logic [DATA_W-1:0]            glitchReg;
  logic                         wrCtrl, wrStatus, wrGlitch;

  assign wrCtrl   = busWr && (busAddr == OFF_CTRL);
  assign wrStatus = busWr && (busAddr == OFF_STATUS);
  assign wrGlitch = busWr && (busAddr == OFF_GLITCH);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      ctrlReg <= '0;
    end else if (wrCtrl) begin
      ctrlReg.cntEn   <= busWdata[0];
      ctrlReg.alarmEn <= busWdata[1];
      ctrlReg.wakeEn  <= busWdata[3];
    end
  end

  // Slow-domain pipeline: moves only on slow pulses.
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      syncPipe <= '0;
    end else if (slowTick) begin
      syncPipe[0] <= ctrlReg;
      for (int i = 1; i < SYNC_STAGES; i++) syncPipe[i] <= syncPipe[i-1];
    end
  end

  assign slowCtrl = syncPipe[SYNC_STAGES-1];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                           pendingFlag <= 1'b0;
    else if (secsMatch && slowCtrl.alarmEn) pendingFlag <= 1'b1;
    else if (wrStatus && busWdata[0])    pendingFlag <= 1'b0;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)         glitchReg <= '0;
    else if (wrGlitch) glitchReg <= busWdata;
  end

  always_comb begin
    strobe         = '0;
    strobe.wrLo    = busWr && (busAddr == OFF_CNTLO) && !slowCtrl.cntEn;
    strobe.wrHi    = busWr && (busAddr == OFF_CNTHI) && !slowCtrl.cntEn;
    strobe.wrAlarm = busWr && (busAddr == OFF_ALARM);
    strobe.advance = slowTick && slowCtrl.cntEn;
  end

  always_comb begin
    busRdata = '0;
    case (busAddr)
      OFF_CTRL:   busRdata = {28'd0, slowCtrl.wakeEn, 1'b0, slowCtrl.alarmEn, slowCtrl.cntEn};
      OFF_STATUS: busRdata = {31'd0, pendingFlag};
      OFF_CNTHI:  busRdata = {{(DATA_W-HI_W){1'b0}}, cntVal[CNT_W-1:32]};
      OFF_CNTLO:  busRdata = cntVal[31:0];
      OFF_ALARM:  busRdata = alarmVal;
      OFF_GLITCH: busRdata = glitchReg;
      default:    busRdata = '0;
    endcase
  end
endmodule

// File: rtl/rtc_lp_counter.sv
module rtc_lp_counter
  import rtc_lp_pkg::*;
#(
  parameter int SYNC_STAGES = 3
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              slowTick,
  input  logic              busWr,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic [DATA_W-1:0] busWdata,
  output logic [DATA_W-1:0] busRdata,
  output logic              alarmIrq,
  output logic              wakeReq
);
  dpStrobe_t        strobe;
  ctrlBits_t        slowCtrl;
  logic [CNT_W-1:0] cntVal;
  logic [SEC_W-1:0] alarmVal;
  logic             secsMatch, pendingFlag;
  logic             slowCntEn, slowAlarmEn;

  rtc_lp_ctrl #(.SYNC_STAGES(SYNC_STAGES)) u_ctrl (
    .clk(clk), .rstN(rstN), .slowTick(slowTick), .busWr(busWr),
    .busAddr(busAddr), .busWdata(busWdata), .cntVal(cntVal),
    .alarmVal(alarmVal), .secsMatch(secsMatch), .strobe(strobe),
    .slowCtrl(slowCtrl), .pendingFlag(pendingFlag), .busRdata(busRdata)
  );

  rtc_lp_datapath u_dp (
    .clk(clk), .rstN(rstN), .strobe(strobe), .wrData(busWdata),
    .cntVal(cntVal), .alarmVal(alarmVal), .secsMatch(secsMatch)
  );

  assign slowCntEn   = slowCtrl.cntEn;
  assign slowAlarmEn = slowCtrl.alarmEn;
  assign alarmIrq    = pendingFlag && slowCtrl.alarmEn;
  assign wakeReq     = pendingFlag && slowCtrl.wakeEn;
endmodule

// File: rtl/rtc_lp_counter_chk.sv
module rtc_lp_counter_chk
  import rtc_lp_pkg::*;
(
  input logic             clk,
  input logic             rstN,
  input logic             slowTick,
  input logic             busWr,
  input logic [CNT_W-1:0] cntVal,
  input logic             slowCntEn,
  input logic             slowAlarmEn,
  input logic             secsMatch,
  input logic             pendingFlag,
  input logic             alarmIrq,
  input logic             wakeReq
);
  p_cnt_step_r2: assert property (@(posedge clk) disable iff (!rstN)
    (slowTick && slowCntEn) |=> (cntVal == $past(cntVal) + CNT_W'(1)));

  p_cnt_idle_r2: assert property (@(posedge clk) disable iff (!rstN)
    (!slowTick && !busWr) |=> $stable(cntVal));

  p_ctrl_wait_r3: assert property (@(posedge clk) disable iff (!rstN)
    !slowTick |=> ($stable(slowCntEn) && $stable(slowAlarmEn)));

  p_load_locked_r5: assert property (@(posedge clk) disable iff (!rstN)
    (slowCntEn && !slowTick) |=> $stable(cntVal));

  p_pend_set_r6: assert property (@(posedge clk) disable iff (!rstN)
    (secsMatch && slowAlarmEn) |=> pendingFlag);

  p_pend_sticky_r7: assert property (@(posedge clk) disable iff (!rstN)
    (pendingFlag && !busWr) |=> pendingFlag);

  p_irq_src_r8: assert property (@(posedge clk) disable iff (!rstN)
    alarmIrq |-> pendingFlag);

  p_wake_src_r8: assert property (@(posedge clk) disable iff (!rstN)
    wakeReq |-> pendingFlag);
endmodule

bind rtc_lp_counter rtc_lp_counter_chk u_chk (
  .clk(clk), .rstN(rstN), .slowTick(slowTick), .busWr(busWr),
  .cntVal(cntVal), .slowCntEn(slowCntEn), .slowAlarmEn(slowAlarmEn),
  .secsMatch(secsMatch), .pendingFlag(pendingFlag),
  .alarmIrq(alarmIrq), .wakeReq(wakeReq)
);

// File: tb/sim_rtc_lp_counter.sv
`timescale 1ns/1ps
module sim_rtc_lp_counter;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        slowTick = 1'b0;
  logic        busWr = 1'b0;
  logic [5:0]  busAddr = '0;
  logic [31:0] busWdata = '0;
  logic [31:0] busRdata;
  logic        alarmIrq, wakeReq;

  int checks = 0;
  int errors = 0;

  always #10 clk = ~clk;

  rtc_lp_counter u0 (
    .clk(clk), .rstN(rstN), .slowTick(slowTick), .busWr(busWr),
    .busAddr(busAddr), .busWdata(busWdata), .busRdata(busRdata),
    .alarmIrq(alarmIrq), .wakeReq(wakeReq)
  );

  // {offset, write data, expected readback}
  localparam logic [69:0] VEC [6] = '{
    {6'h24, 32'h1234_5678, 32'h1234_5678},
    {6'h30, 32'h4173_6166, 32'h4173_6166},
    {6'h08, 32'hFFFF_FFFF, 32'h0000_0000},
    {6'h2C, 32'hA5A5_A5A5, 32'h0000_0000},
    {6'h3C, 32'h0F0F_0F0F, 32'h0000_0000},
    {6'h18, 32'h0000_0000, 32'h0000_0000}
  };

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic busWrite(input logic [5:0] a, input logic [31:0] d);
    @(negedge clk);
    busWr = 1'b1; busAddr = a; busWdata = d;
    @(negedge clk);
    busWr = 1'b0;
  endtask

  task automatic busRead(input logic [5:0] a, output logic [31:0] d);
    @(negedge clk);
    busAddr = a;
    #1;
    d = busRdata;
  endtask

  task automatic tickN(input int n);
    @(negedge clk);
    slowTick = 1'b1;
    repeat (n) @(negedge clk);
    slowTick = 1'b0;
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    logic [31:0] v;
    repeat (3) @(negedge clk);
    rstN = 1'b1;

    // R1 reset state
    busRead(6'h04, v); check("R1 ctrl", v, 0);
    busRead(6'h18, v); check("R1 status", v, 0);
    busRead(6'h20, v); check("R1 cntlo", v, 0);
    busRead(6'h1C, v); check("R1 cnthi", v, 0);
    busRead(6'h30, v); check("R1 glitch", v, 0);
    check("R1 irq/wake", {30'd0, alarmIrq, wakeReq}, 0);

    // Vector table: R6 alarm, R9 glitch, R10 unmapped
    for (int i = 0; i < 6; i++) begin
      busWrite(VEC[i][69:64], VEC[i][63:32]);
      busRead(VEC[i][69:64], v);
      check("R6/R9/R10 table", v, VEC[i][31:0]);
    end
    busRead(6'h30, v); check("R10 glitch untouched", v, 32'h4173_6166);
    busRead(6'h24, v); check("R10 alarm untouched", v, 32'h1234_5678);

    // R5 load while stopped, R4 read layout
    busWrite(6'h20, 32'hFFFF_FFFE);
    busWrite(6'h1C, 32'hFFFF_0003);
    busRead(6'h20, v); check("R4 cntlo", v, 32'hFFFF_FFFE);
    busRead(6'h1C, v); check("R4 cnthi", v, 32'h0000_7FFF & 32'hFFFF_0003);

    // R3 enable lands on third pulse; R2 hold while disabled
    busWrite(6'h04, 32'h1);
    tickN(2);
    busRead(6'h04, v); check("R3 ctrl after 2 pulses", v, 0);
    busRead(6'h20, v); check("R2 hold while disabled", v, 32'hFFFF_FFFE);
    tickN(1);
    busRead(6'h04, v); check("R3 ctrl after 3 pulses", v, 1);
    busRead(6'h20, v); check("R2 no step on landing pulse", v, 32'hFFFF_FFFE);
    tickN(1);
    busRead(6'h20, v); check("R2 one step", v, 32'hFFFF_FFFF);
    tickN(1);
    busRead(6'h20, v); check("R11 low wraps", v, 0);
    busRead(6'h1C, v); check("R11 carry to high", v, 4);

    // R5 loads ignored while running
    busWrite(6'h20, 32'h5);
    busWrite(6'h1C, 32'h7);
    busRead(6'h20, v); check("R5 lo locked", v, 0);
    busRead(6'h1C, v); check("R5 hi locked", v, 4);

    // R2 one second = 32768 pulses
    tickN(32768);
    busRead(6'h20, v); check("R2 one second", v, 32'h0000_8000);
    busRead(6'h1C, v); check("R2 high unchanged", v, 4);

    // R6 mismatch does not fire; seconds now 0x80001
    busWrite(6'h24, 32'h0008_0005);
    busWrite(6'h04, 32'h0B);
    tickN(3);
    busRead(6'h04, v); check("R3 all enables", v, 32'h0B);
    busRead(6'h18, v); check("R6 no fire on mismatch", v, 0);
    check("R8 idle lines", {30'd0, alarmIrq, wakeReq}, 0);
    busWrite(6'h24, 32'h0008_0001);
    busRead(6'h18, v); check("R6 fire on match", v, 1);
    check("R8 irq and wake", {30'd0, alarmIrq, wakeReq}, 32'h3);

    // R7 set wins over clear
    busWrite(6'h18, 32'h1);
    busRead(6'h18, v); check("R7 set priority", v, 1);

    // R8 wake gating
    busWrite(6'h04, 32'h03);
    tickN(3);
    check("R8 wake off irq on", {30'd0, alarmIrq, wakeReq}, 32'h2);

    busWrite(6'h24, 32'h0);
    busWrite(6'h18, 32'h0);
    busRead(6'h18, v); check("R7 write 0 keeps", v, 1);

    // R8 irq gating with pending still set
    busWrite(6'h04, 32'h01);
    tickN(3);
    check("R8 irq gated off", {30'd0, alarmIrq, wakeReq}, 0);
    busRead(6'h18, v); check("R8 pending kept", v, 1);
    busWrite(6'h18, 32'h1);
    busRead(6'h18, v); check("R7 w1c clears", v, 0);

    // R11 full wrap
    busWrite(6'h04, 32'h0);
    tickN(3);
    busRead(6'h04, v); check("R3 disable lands", v, 0);
    busWrite(6'h1C, 32'h0000_7FFF);
    busWrite(6'h20, 32'hFFFF_FFFF);
    busRead(6'h1C, v); check("R5 hi load", v, 32'h7FFF);
    busWrite(6'h04, 32'h1);
    tickN(3);
    busRead(6'h20, v); check("R11 before wrap", v, 32'hFFFF_FFFF);
    tickN(1);
    busRead(6'h20, v); check("R11 wrap lo", v, 0);
    busRead(6'h1C, v); check("R11 wrap hi", v, 0);

    // R1 reset mid-run
    busWrite(6'h24, 32'h77);
    @(negedge clk); rstN = 1'b0;
    repeat (2) @(negedge clk); rstN = 1'b1;
    busRead(6'h04, v); check("R1 ctrl after reset", v, 0);
    busRead(6'h24, v); check("R1 alarm after reset", v, 0);
    busRead(6'h30, v); check("R1 glitch after reset", v, 0);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule